// File: doc/BRIEF.md
# Escape Clock and Timeout Divider

This block sits in the lane byte clock domain of a serial display link host. It divides the byte clock into two slow, one-cycle enables. The first paces the low-power escape logic. The second is a timeout tick. Three 16-bit watchers count timeout ticks while their activity input is held high. One watches high-speed transmit, one watches low-power receive and one watches bus turnaround. When a watcher reaches its programmed count, it raises a sticky error flag. Software clears each flag by writing a one to it.

Software loads a clock word that holds both divisors. The escape divisor is normally chosen as (lane rate in Mbit/s / 8) / 20 + 1, which keeps the escape rate at or below 20 MHz. Software then loads a timeout word that holds the transmit and receive limits, and a separate turnaround limit word. A typical turnaround limit is 0xD00. Each word is applied at the clock edge on which its write enable is high. All three counts are kept in units of timeout ticks, not byte clocks.

Top module: `esc_tmo_unit`

## Requirements
- R1: Reset applies the following, and nothing starts until software writes a configuration: both ticks are low, err_flags is 0, both divisors are 0 and all three limits are 0.
- R2: Bits [7:0] of the clock word set the escape divisor N. For N of 2 or more, esc_tick is high for exactly one cycle in every N cycles. The first pulse comes in the N-th cycle after the edge that took the write, and every write restarts the phase.
- R3: Bits [15:8] of the clock word set the timeout divisor. tmo_tick behaves as in R2 and runs independently of esc_tick.
- R4: A divisor of 0 or 1 keeps the matching tick low.
- R5: Bits [31:16] of the timeout word set the transmit limit and bits [15:0] set the receive limit. The turnaround word bits [15:0] set the turnaround limit. The err_flags bits are: bit 0 for transmit (hs_tx_busy), bit 1 for receive (lp_rx_busy), bit 2 for turnaround (bta_busy). A flag sets at the edge of the L-th timeout tick seen while its activity input stays continuously high, where L is the limit.
- R6: Any cycle with the activity input low resets that watcher's tick count to zero.
- R7: A limit of 0 disables that watcher, so it never sets its flag.
- R8: Error flags are sticky. A cycle with err_clr_we high clears each flag whose err_clr bit is 1. Flags whose err_clr bit is 0 are left unchanged.
- R9: If a flag is set and cleared at the same edge, the flag ends up set.
- R10: Watchers advance only on timeout ticks. With the timeout divisor at 0 or 1, no flag can set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_cfg_we | input | 1 | Load the clock word |
| clk_cfg_wdata | input | 32 | Clock word: escape divisor [7:0], timeout divisor [15:8] |
| tmo_cfg_we | input | 1 | Load the timeout word |
| tmo_cfg_wdata | input | 32 | Timeout word: transmit limit [31:16], receive limit [15:0] |
| bta_cfg_we | input | 1 | Load the turnaround limit |
| bta_cfg_wdata | input | 16 | Turnaround limit |
| hs_tx_busy | input | 1 | High-speed transmit in progress |
| lp_rx_busy | input | 1 | Low-power receive in progress |
| bta_busy | input | 1 | Bus turnaround in progress |
| err_clr_we | input | 1 | Apply the clear mask |
| err_clr | input | 3 | Write-one-to-clear mask for err_flags |
| esc_tick | output | 1 | Escape clock enable |
| tmo_tick | output | 1 | Timeout tick enable |
| err_flags | output | 3 | Sticky timeout errors |

## Verification
The bench targets the following corner cases:
- **Divisor phase and period.** An off-by-one divider would put the first tick one cycle early or late, or stretch the period to N+1.
- **Divisors of 0 and 1.** A divider that treats 1 as "divide by one" would hold the tick high permanently.
- **Activity gaps.** An activity pattern with short gaps checks that the count reloads. A watcher that kept its count across a gap would raise a false error.
- **Clears.** Clears are issued with partial masks, and one clear is aligned to the very edge of a new expiry. A design that let a clear beat a set would lose that error, and one that cleared whole words would wipe unrelated flags.
- **Disabled limits and a stopped tick.** These runs catch a watcher that counts byte clocks, or one that fires at a limit of zero.

// File: rtl/esc_tmo_pkg.sv
package esc_tmo_pkg;
  localparam int CFG_W     = 32;
  localparam int DIV_W     = 8;
  localparam int CNT_W     = 16;
  localparam int NUM_WATCH = 3;
  // field positions inside the configuration words
  localparam int ESC_DIV_LSB = 0;
  localparam int TMO_DIV_LSB = DIV_W;
  localparam int TX_LIM_LSB  = CNT_W;
  localparam int RX_LIM_LSB  = 0;
  // watcher slots in err_flags
  localparam int IDX_TX  = 0;
  localparam int IDX_RX  = 1;
  localparam int IDX_BTA = 2;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] div_in,
  output logic         tick
);
  logic [W-1:0] div_q, div_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         run;

  assign run  = (div_q > {{(W-1){1'b0}}, 1'b1});
  assign tick = run && (cnt_q == div_q - {{(W-1){1'b0}}, 1'b1});

  always_comb begin
    div_d = load ? div_in : div_q;
    if (load || !run || tick) cnt_d = '0;
    else                      cnt_d = cnt_q + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/timeout_watch.sv
module timeout_watch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] limit_in,
  input  logic         tick,
  input  logic         active,
  input  logic         clr,
  output logic         err
);
  logic [W-1:0] lim_q, lim_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         err_q, err_d;
  logic [W:0]   cnt_inc;
  logic         armed, expire;

  assign armed   = (lim_q != '0);
  assign cnt_inc = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
  assign expire  = active && armed && tick && (cnt_inc >= {1'b0, lim_q});

  always_comb begin
    lim_d = load ? limit_in : lim_q;
    if (!active || expire) cnt_d = '0;
    else if (tick && armed) cnt_d = cnt_inc[W-1:0];
    else                    cnt_d = cnt_q;
    err_d = expire | (err_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      lim_q <= lim_d;
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign err = err_q;
endmodule

// File: rtl/esc_tmo_unit.sv
module esc_tmo_unit
  import esc_tmo_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clk_cfg_we,
  input  logic [CFG_W-1:0]     clk_cfg_wdata,
  input  logic                 tmo_cfg_we,
  input  logic [CFG_W-1:0]     tmo_cfg_wdata,
  input  logic                 bta_cfg_we,
  input  logic [CNT_W-1:0]     bta_cfg_wdata,
  input  logic                 hs_tx_busy,
  input  logic                 lp_rx_busy,
  input  logic                 bta_busy,
  input  logic                 err_clr_we,
  input  logic [NUM_WATCH-1:0] err_clr,
  output logic                 esc_tick,
  output logic                 tmo_tick,
  output logic [NUM_WATCH-1:0] err_flags
);
  // reset: asserted asynchronously, released after two clean edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic unused_cfg_hi;
  assign unused_cfg_hi = ^clk_cfg_wdata[CFG_W-1:2*DIV_W];

  tick_divider #(.W(DIV_W)) u_esc_div (
    .clk(clk), .rst_n(rst_int_n), .load(clk_cfg_we),
    .div_in(clk_cfg_wdata[ESC_DIV_LSB +: DIV_W]), .tick(esc_tick));

  tick_divider #(.W(DIV_W)) u_tmo_div (
    .clk(clk), .rst_n(rst_int_n), .load(clk_cfg_we),
    .div_in(clk_cfg_wdata[TMO_DIV_LSB +: DIV_W]), .tick(tmo_tick));

  logic [NUM_WATCH-1:0][CNT_W-1:0] lim_in;
  logic [NUM_WATCH-1:0]            lim_ld;
  logic [NUM_WATCH-1:0]            act;
  logic [NUM_WATCH-1:0]            clr_vec;

  assign lim_in[IDX_TX]  = tmo_cfg_wdata[TX_LIM_LSB +: CNT_W];
  assign lim_in[IDX_RX]  = tmo_cfg_wdata[RX_LIM_LSB +: CNT_W];
  assign lim_in[IDX_BTA] = bta_cfg_wdata;
  assign lim_ld[IDX_TX]  = tmo_cfg_we;
  assign lim_ld[IDX_RX]  = tmo_cfg_we;
  assign lim_ld[IDX_BTA] = bta_cfg_we;
  assign act[IDX_TX]     = hs_tx_busy;
  assign act[IDX_RX]     = lp_rx_busy;
  assign act[IDX_BTA]    = bta_busy;
  assign clr_vec         = err_clr_we ? err_clr : '0;

  for (genvar g = 0; g < NUM_WATCH; g++) begin : g_watch
    timeout_watch #(.W(CNT_W)) u_watch (
      .clk(clk), .rst_n(rst_int_n), .load(lim_ld[g]), .limit_in(lim_in[g]),
      .tick(tmo_tick), .active(act[g]), .clr(clr_vec[g]), .err(err_flags[g]));
  end
endmodule

// File: rtl/esc_tmo_unit_chk.sv
module esc_tmo_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clk_cfg_we,
  input logic [31:0] clk_cfg_wdata,
  input logic        hs_tx_busy,
  input logic        err_clr_we,
  input logic [2:0]  err_clr,
  input logic        esc_tick,
  input logic        tmo_tick,
  input logic [2:0]  err_flags
);
  logic       past_ok;
  logic [2:0] keep_mask;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end
  assign keep_mask = err_clr_we ? ~err_clr : 3'b111;

  // R2: an escape tick never lasts two cycles
  a_r2_esc_single: assert property (@(posedge clk) disable iff (!rst_n)
    esc_tick |=> !esc_tick);
  // R3: a timeout tick never lasts two cycles
  a_r3_tmo_single: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_tick |=> !tmo_tick);
  // R4: loading a divisor below 2 silences the escape tick
  a_r4_esc_off: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_cfg_we && clk_cfg_wdata[7:0] < 8'd2) |=> !esc_tick);
  // R8: a flag stays set unless its clear bit was written
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |=> ((err_flags & ($past(err_flags) & $past(keep_mask)))
                 == ($past(err_flags) & $past(keep_mask))));
  // R10: a flag can only rise at the edge of a timeout tick
  a_r10_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ((err_flags & ~$past(err_flags)) != 3'b000)) |-> $past(tmo_tick));
  // R6: the transmit flag only rises while transmit is busy
  a_r6_tx_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(err_flags[0])) |-> $past(hs_tx_busy));
endmodule

bind esc_tmo_unit esc_tmo_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clk_cfg_we(clk_cfg_we), .clk_cfg_wdata(clk_cfg_wdata),
  .hs_tx_busy(hs_tx_busy), .err_clr_we(err_clr_we), .err_clr(err_clr),
  .esc_tick(esc_tick), .tmo_tick(tmo_tick), .err_flags(err_flags));

// File: tb/esc_tmo_unit_test.sv
module esc_tmo_unit_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_cfg_we = 1'b0;
  logic [31:0] clk_cfg_wdata = '0;
  logic        tmo_cfg_we = 1'b0;
  logic [31:0] tmo_cfg_wdata = '0;
  logic        bta_cfg_we = 1'b0;
  logic [15:0] bta_cfg_wdata = '0;
  logic        hs_tx_busy = 1'b0, lp_rx_busy = 1'b0, bta_busy = 1'b0;
  logic        err_clr_we = 1'b0;
  logic [2:0]  err_clr = '0;
  logic        esc_tick, tmo_tick;
  logic [2:0]  err_flags;

  int checks = 0, fails = 0;
  bit cmp_en = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  esc_tmo_unit uut (
    .clk(clk), .rst_n(rst_n), .clk_cfg_we(clk_cfg_we), .clk_cfg_wdata(clk_cfg_wdata),
    .tmo_cfg_we(tmo_cfg_we), .tmo_cfg_wdata(tmo_cfg_wdata), .bta_cfg_we(bta_cfg_we),
    .bta_cfg_wdata(bta_cfg_wdata), .hs_tx_busy(hs_tx_busy), .lp_rx_busy(lp_rx_busy),
    .bta_busy(bta_busy), .err_clr_we(err_clr_we), .err_clr(err_clr),
    .esc_tick(esc_tick), .tmo_tick(tmo_tick), .err_flags(err_flags));

  // behavioural reference: phase = cycles since the last clock-word write
  int m_ediv = 0, m_tdiv = 0, m_k = 0;
  int m_lim[3] = '{0, 0, 0};
  int m_nt[3]  = '{0, 0, 0};
  bit [2:0] m_err = '0;

  function automatic bit ref_tick(int div, int k);
    return (div >= 2) && ((k % div) == div - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ediv = 0; m_tdiv = 0; m_k = 0; m_err = '0;
      for (int i = 0; i < 3; i++) begin m_lim[i] = 0; m_nt[i] = 0; end
    end else begin
      bit t;
      bit [2:0] a;
      bit [2:0] setv;
      t = ref_tick(m_tdiv, m_k);
      a = {bta_busy, lp_rx_busy, hs_tx_busy};
      setv = '0;
      for (int i = 0; i < 3; i++) begin
        if (!a[i]) m_nt[i] = 0;
        else if (t && m_lim[i] != 0) begin
          if (m_nt[i] + 1 >= m_lim[i]) begin setv[i] = 1'b1; m_nt[i] = 0; end
          else m_nt[i] = m_nt[i] + 1;
        end
      end
      m_err = setv | (m_err & ~(err_clr_we ? err_clr : 3'b000));
      if (tmo_cfg_we) begin
        m_lim[0] = int'(tmo_cfg_wdata[31:16]);
        m_lim[1] = int'(tmo_cfg_wdata[15:0]);
      end
      if (bta_cfg_we) m_lim[2] = int'(bta_cfg_wdata);
      if (clk_cfg_we) begin
        m_ediv = int'(clk_cfg_wdata[7:0]);
        m_tdiv = int'(clk_cfg_wdata[15:8]);
        m_k = 0;
      end else m_k = m_k + 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R2 esc_tick vs model", int'(esc_tick), int'(ref_tick(m_ediv, m_k)));
      chk("R3 tmo_tick vs model", int'(tmo_tick), int'(ref_tick(m_tdiv, m_k)));
      chk("R5 err_flags vs model", int'(err_flags), int'(m_err));
    end
  end

  task automatic wr_clk(int esc_div, int tmo_div);
    @(negedge clk);
    clk_cfg_we = 1'b1; clk_cfg_wdata = {16'h0, 8'(tmo_div), 8'(esc_div)};
    @(negedge clk);
    clk_cfg_we = 1'b0;
  endtask

  task automatic wr_tmo(int tx, int rx);
    @(negedge clk);
    tmo_cfg_we = 1'b1; tmo_cfg_wdata = {16'(tx), 16'(rx)};
    @(negedge clk);
    tmo_cfg_we = 1'b0;
  endtask

  task automatic wr_bta(int lim);
    @(negedge clk);
    bta_cfg_we = 1'b1; bta_cfg_wdata = 16'(lim);
    @(negedge clk);
    bta_cfg_we = 1'b0;
  endtask

  task automatic clear(bit [2:0] m);
    @(negedge clk);
    err_clr_we = 1'b1; err_clr = m;
    @(negedge clk);
    err_clr_we = 1'b0; err_clr = '0;
  endtask

  // after a clock-word write, count pulses over n negedges starting at phase 0
  task automatic count_ticks(int n, output int ne, output int nt, output int first_e);
    ne = 0; nt = 0; first_e = -1;
    for (int i = 0; i < n; i++) begin
      if (esc_tick) begin ne++; if (first_e < 0) first_e = i; end
      if (tmo_tick) nt++;
      if (i < n - 1) @(negedge clk);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int ne, nt, fe;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    cmp_en = 1;
    // R1 reset state
    chk("R1 esc_tick after reset", int'(esc_tick), 0);
    chk("R1 tmo_tick after reset", int'(tmo_tick), 0);
    chk("R1 err_flags after reset", int'(err_flags), 0);
    hs_tx_busy = 1'b1;
    idle(20);
    chk("R1 no flag before configuration", int'(err_flags), 0);
    hs_tx_busy = 1'b0;

    // R2 / R3 independent dividers
    wr_clk(4, 5);
    count_ticks(40, ne, nt, fe);
    chk("R2 escape pulses in 40 cycles, div 4", ne, 10);
    chk("R2 first escape pulse phase", fe, 3);
    chk("R3 timeout pulses in 40 cycles, div 5", nt, 8);
    wr_clk(7, 2);
    count_ticks(42, ne, nt, fe);
    chk("R2 escape pulses div 7", ne, 6);
    chk("R2 phase restarts after write", fe, 6);
    chk("R3 timeout pulses div 2", nt, 21);

    // R4 divisors 0 and 1
    wr_clk(1, 0);
    count_ticks(30, ne, nt, fe);
    chk("R4 escape divisor 1 silent", ne, 0);
    chk("R4 timeout divisor 0 silent", nt, 0);
    wr_clk(0, 1);
    count_ticks(30, ne, nt, fe);
    chk("R4 escape divisor 0 silent", ne, 0);
    chk("R4 timeout divisor 1 silent", nt, 0);

    // R10 no tick, no error
    wr_tmo(1, 1);
    wr_bta(1);
    hs_tx_busy = 1'b1; lp_rx_busy = 1'b1; bta_busy = 1'b1;
    idle(50);
    chk("R10 no flag while timeout tick is stopped", int'(err_flags), 0);
    hs_tx_busy = 1'b0; lp_rx_busy = 1'b0; bta_busy = 1'b0;

    // R7 zero limit disables
    wr_tmo(0, 0);
    wr_bta(0);
    wr_clk(3, 2);
    hs_tx_busy = 1'b1; lp_rx_busy = 1'b1; bta_busy = 1'b1;
    idle(60);
    chk("R7 zero limits never flag", int'(err_flags), 0);
    hs_tx_busy = 1'b0; lp_rx_busy = 1'b0; bta_busy = 1'b0;

    // R6 gaps reload the count: limit 3 ticks (6 cycles), busy 4 on, 1 off
    wr_tmo(3, 0);
    for (int r = 0; r < 10; r++) begin
      hs_tx_busy = 1'b1; idle(4);
      hs_tx_busy = 1'b0; idle(1);
    end
    chk("R6 gapped activity raises no transmit flag", int'(err_flags), 0);

    // R5 continuous activity expires: transmit bit 0 only
    hs_tx_busy = 1'b1;
    idle(10);
    chk("R5 transmit flag in bit 0", int'(err_flags), 1);
    hs_tx_busy = 1'b0;
    wr_bta(2);
    bta_busy = 1'b1;
    idle(10);
    bta_busy = 1'b0;
    chk("R5 turnaround flag in bit 2", int'(err_flags), 5);
    wr_tmo(0, 0);
    wr_tmo(0, 2);
    lp_rx_busy = 1'b1;
    idle(10);
    lp_rx_busy = 1'b0;
    chk("R5 receive limit in low half sets bit 1", int'(err_flags), 7);

    // R8 write-one-to-clear with partial masks
    clear(3'b001);
    chk("R8 clear bit 0 only", int'(err_flags), 6);
    idle(5);
    chk("R8 flags stay without clear", int'(err_flags), 6);
    clear(3'b100);
    chk("R8 clear bit 2 leaves bit 1", int'(err_flags), 2);
    @(negedge clk);
    err_clr = 3'b111; err_clr_we = 1'b0;
    @(negedge clk);
    chk("R8 mask ignored without write enable", int'(err_flags), 2);
    err_clr = 3'b000;
    clear(3'b010);
    chk("R8 all cleared", int'(err_flags), 0);

    // R9 set wins over clear at the same edge: limit 1, tick every 2
    wr_tmo(1, 0);
    hs_tx_busy = 1'b1;
    while (!tmo_tick) @(negedge clk);
    err_clr_we = 1'b1; err_clr = 3'b001;
    @(negedge clk);
    err_clr_we = 1'b0; err_clr = '0;
    chk("R9 set beats clear on the same edge", int'(err_flags), 1);
    hs_tx_busy = 1'b0;
    clear(3'b001);
    chk("R8 clear after busy drops", int'(err_flags), 0);
    idle(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule